// File: doc/BRIEF.md
# Program Status Register Unit

This block holds the processor status word as three separately writable views that share one 32-bit word. The application view carries the negative, zero, carry and overflow condition flags and a sticky saturation flag. The interrupt view carries the number of the exception being serviced. The execution view carries the conditional-block and interruptible-multiple-transfer state, together with a state bit that is pinned at 1.

The condition flags load from the ALU whenever the flag-update strobe is high. A saturation event sets the saturation flag, and only an explicit write clears it again. Software-style masked writes reach the application and execution views through one shared data and mask bus. Any write that tries to clear the state bit leaves the bit at 1 and raises a one-cycle fault. The exception number changes only on exception entry or exit. All state is registered, so an update shows at the outputs after the clock edge on which its inputs were sampled.

Top module: `psr_unit`

## Requirements
- R1: While reset is low, and after it is released, the word reads 0x0100_0000: bit 24 is 1 and every other bit is 0. fault_o is 0.
- R2: When flag_upd_i is 1, bits 31, 30, 29 and 28 (negative, zero, carry, overflow) take alu_n_i, alu_z_i, alu_c_i and alu_v_i on the next edge. When neither flag_upd_i nor a masked application write touches them, they hold.
- R3: sat_i=1 sets bit 27 (saturation) on the next edge. The bit stays 1 through later flag updates. Only an application write with wmask_i[27]=1 and wdata_i[27]=0 clears it.
- R4: app_we_i=1 replaces each bit of [31:27] whose wmask_i bit is 1 with the matching wdata_i bit. All other bits of the word are unaffected by this write.
- R5: When an application write and a flag update fall in the same cycle, masked bits take wdata_i and unmasked flag bits take the ALU values. When sat_i=1 coincides with a write that clears bit 27, bit 27 ends at 1.
- R6: exe_we_i=1 replaces each bit of [26:25] and [15:10] (conditional-execution state) whose wmask_i bit is 1 with wdata_i. All other bits are unaffected by this write.
- R7: Bit 24 is always 1. If exe_we_i=1, wmask_i[24]=1 and wdata_i[24]=0 at an edge, fault_o is 1 for the following cycle only. Otherwise fault_o is 0.
- R8: Bits [8:0] load exc_num_i on an edge where exc_enter_i or exc_exit_i is 1. Otherwise they hold, and writes through the shared bus never change them.
- R9: apsr_o is the word ANDed with 0xF800_0000, ipsr_o is the word ANDed with 0x0000_01FF, and epsr_o is the word ANDed with 0x0700_FC00. psr_o is their OR, and bits [23:16] and bit 9 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_upd_i | input | 1 | Load condition flags from the ALU |
| alu_n_i | input | 1 | ALU negative result |
| alu_z_i | input | 1 | ALU zero result |
| alu_c_i | input | 1 | ALU carry/borrow result |
| alu_v_i | input | 1 | ALU overflow result |
| sat_i | input | 1 | Saturation event, sets the sticky flag |
| app_we_i | input | 1 | Masked write to application view |
| exe_we_i | input | 1 | Masked write to execution view |
| wdata_i | input | 32 | Write data, word-aligned bit positions |
| wmask_i | input | 32 | Per-bit write enable |
| exc_enter_i | input | 1 | Exception entry, load number |
| exc_exit_i | input | 1 | Exception return, load number |
| exc_num_i | input | 9 | Exception number to load |
| psr_o | output | 32 | Combined status word |
| apsr_o | output | 32 | Application view |
| ipsr_o | output | 32 | Interrupt view |
| epsr_o | output | 32 | Execution view |
| fault_o | output | 1 | One-cycle pulse on an attempt to clear the state bit |

## Verification
The two functions that collide are the ALU flag update and the masked application write. Both target bits [31:28] in the same cycle, and the saturation event can meet a write that clears bit 27. Directed cycles assert flag_upd_i, app_we_i and sat_i together with partial masks. A bench model then judges the result bit by bit: mask beats ALU, and set beats clear. Random traffic keeps provoking the same overlap, and the views are compared on every clock.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FLAG_W  = 5;   // N Z C V Q
  localparam int unsigned IT_W    = 8;   // {[26:25],[15:10]}
  localparam int unsigned EXC_MAX = 9;   // bit 9 stays free
  localparam int unsigned BIT_N   = 31;
  localparam int unsigned BIT_Q   = 27;
  localparam int unsigned BIT_T   = 24;
  localparam logic [WORD_W-1:0] APP_MASK = 32'hF800_0000;
  localparam logic [WORD_W-1:0] EXE_MASK = 32'h0700_FC00;
  localparam logic [WORD_W-1:0] INT_MASK = 32'h0000_01FF;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic q;
  } app_flags_t;

  function automatic logic [IT_W-1:0] it_pick(input logic [WORD_W-1:0] w);
    return {w[26:25], w[15:10]};
  endfunction
endpackage

// File: rtl/psr_app_flags.sv
module psr_app_flags
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_upd_i,
  input  logic [3:0]       alu_nzcv_i,
  input  logic             sat_i,
  input  logic             we_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] wmask_i,
  output app_flags_t       flags_o
);
  app_flags_t q_r, d;
  logic [FLAG_W-1:0] v;

  always_comb begin
    v = q_r;
    if (flag_upd_i) v[FLAG_W-1:1] = alu_nzcv_i;
    if (we_i)       v = (v & ~wmask_i) | (wdata_i & wmask_i);
    if (sat_i)      v[0] = 1'b1;  // set beats clear
    d = app_flags_t'(v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= d;
  end

  assign flags_o = q_r;
endmodule

// File: rtl/psr_exec_state.sv
module psr_exec_state
  import psr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IT_W-1:0] it_wdata_i,
  input  logic [IT_W-1:0] it_wmask_i,
  input  logic            t_wen_i,
  input  logic            t_wdata_i,
  output logic [IT_W-1:0] it_o,
  output logic            t_o,
  output logic            fault_o
);
  logic [IT_W-1:0] it_r;
  logic            t_r;
  logic            fault_r;
  logic            clr_try;

  assign clr_try = we_i & t_wen_i & ~t_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      it_r    <= '0;
      t_r     <= 1'b1;
      fault_r <= 1'b0;
    end else begin
      if (we_i) it_r <= (it_r & ~it_wmask_i) | (it_wdata_i & it_wmask_i);
      t_r     <= 1'b1;  // clears are refused
      fault_r <= clr_try;
    end
  end

  assign it_o    = it_r;
  assign t_o     = t_r;
  assign fault_o = fault_r;
endmodule

// File: rtl/psr_exc_num.sv
module psr_exc_num #(
  parameter int unsigned EXC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic [EXC_W-1:0] num_i,
  output logic [EXC_W-1:0] num_o
);
  logic [EXC_W-1:0] num_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               num_r <= '0;
    else if (enter_i || exit_i) num_r <= num_i;
  end

  assign num_o = num_r;
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int unsigned EXC_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_upd_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic              alu_c_i,
  input  logic              alu_v_i,
  input  logic              sat_i,
  input  logic              app_we_i,
  input  logic              exe_we_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       wmask_i,
  input  logic              exc_enter_i,
  input  logic              exc_exit_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic [31:0]       psr_o,
  output logic [31:0]       apsr_o,
  output logic [31:0]       ipsr_o,
  output logic [31:0]       epsr_o,
  output logic              fault_o
);
  localparam int unsigned EXC_PAD = WORD_W - EXC_W;

  app_flags_t      flags;
  logic [IT_W-1:0] it;
  logic            t_bit;
  logic [EXC_W-1:0] exc_num;

  psr_app_flags u_app (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_upd_i (flag_upd_i),
    .alu_nzcv_i ({alu_n_i, alu_z_i, alu_c_i, alu_v_i}),
    .sat_i      (sat_i),
    .we_i       (app_we_i),
    .wdata_i    (wdata_i[BIT_N:BIT_Q]),
    .wmask_i    (wmask_i[BIT_N:BIT_Q]),
    .flags_o    (flags)
  );

  psr_exec_state u_exe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (exe_we_i),
    .it_wdata_i (it_pick(wdata_i)),
    .it_wmask_i (it_pick(wmask_i)),
    .t_wen_i    (wmask_i[BIT_T]),
    .t_wdata_i  (wdata_i[BIT_T]),
    .it_o       (it),
    .t_o        (t_bit),
    .fault_o    (fault_o)
  );

  psr_exc_num #(.EXC_W(EXC_W)) u_exc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (exc_enter_i),
    .exit_i  (exc_exit_i),
    .num_i   (exc_num_i),
    .num_o   (exc_num)
  );

  assign apsr_o = {flags, 27'd0};
  assign ipsr_o = {{EXC_PAD{1'b0}}, exc_num};
  assign epsr_o = {5'd0, it[7:6], t_bit, 8'd0, it[5:0], 10'd0};
  assign psr_o  = apsr_o | ipsr_o | epsr_o;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk #(
  parameter int unsigned EXC_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flag_upd_i,
  input logic              sat_i,
  input logic              app_we_i,
  input logic              exe_we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       wmask_i,
  input logic              exc_enter_i,
  input logic              exc_exit_i,
  input logic [31:0]       psr_o,
  input logic [31:0]       apsr_o,
  input logic [31:0]       ipsr_o,
  input logic [31:0]       epsr_o,
  input logic              fault_o
);
  // R7: the state bit never reads 0
  a_r7_t_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_o[24]);
  // R7: a refused clear pulses fault
  a_r7_fault_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exe_we_i && wmask_i[24] && !wdata_i[24]) |=> fault_o);
  a_r7_no_spurious_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exe_we_i && wmask_i[24] && !wdata_i[24]) |=> !fault_o);
  // R2: flags hold without a source
  a_r2_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_upd_i && !app_we_i) |=> $stable(psr_o[31:28]));
  // R3: saturation flag is sticky
  a_r3_q_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_o[27] && !(app_we_i && wmask_i[27] && !wdata_i[27])) |=> psr_o[27]);
  // R3: set on a saturation event
  a_r3_q_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_i |=> psr_o[27]);
  // R8: exception number only moves on entry or exit
  a_r8_exc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_enter_i && !exc_exit_i) |=> $stable(ipsr_o));
  // R6: execution view untouched without its write
  a_r6_exe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exe_we_i |=> $stable(epsr_o));
  // R9: views partition the word
  a_r9_views: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_o == (apsr_o | ipsr_o | epsr_o)) && ((psr_o & 32'h00FF_0200) == 32'd0));
endmodule

bind psr_unit psr_unit_chk #(.EXC_W(EXC_W)) u_psr_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flag_upd_i  (flag_upd_i),
  .sat_i       (sat_i),
  .app_we_i    (app_we_i),
  .exe_we_i    (exe_we_i),
  .wdata_i     (wdata_i),
  .wmask_i     (wmask_i),
  .exc_enter_i (exc_enter_i),
  .exc_exit_i  (exc_exit_i),
  .psr_o       (psr_o),
  .apsr_o      (apsr_o),
  .ipsr_o      (ipsr_o),
  .epsr_o      (epsr_o),
  .fault_o     (fault_o)
);

// File: tb/psr_unit_bench.sv
`timescale 1ns/1ps
module psr_unit_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flag_upd, alu_n, alu_z, alu_c, alu_v, sat, app_we, exe_we;
  logic [31:0] wdata, wmask;
  logic enter, leave;
  logic [8:0] exc_num;
  logic [31:0] psr, apsr, ipsr, epsr;
  logic fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_psr;
  logic        m_fault;

  always #2.5 clk = ~clk;

  psr_unit u_psr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .flag_upd_i(flag_upd),
    .alu_n_i(alu_n), .alu_z_i(alu_z), .alu_c_i(alu_c), .alu_v_i(alu_v),
    .sat_i(sat), .app_we_i(app_we), .exe_we_i(exe_we),
    .wdata_i(wdata), .wmask_i(wmask), .exc_enter_i(enter), .exc_exit_i(leave),
    .exc_num_i(exc_num), .psr_o(psr), .apsr_o(apsr), .ipsr_o(ipsr),
    .epsr_o(epsr), .fault_o(fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4 apsr", apsr, m_psr & 32'hF800_0000);
    chk("R8 ipsr", ipsr, m_psr & 32'h0000_01FF);
    chk("R6 epsr", epsr, m_psr & 32'h0700_FC00);
    chk("R9 psr", psr, m_psr);
    chk("R7 fault", {31'd0, fault}, {31'd0, m_fault});
  endtask

  task automatic idle();
    flag_upd = 0; alu_n = 0; alu_z = 0; alu_c = 0; alu_v = 0; sat = 0;
    app_we = 0; exe_we = 0; wdata = '0; wmask = '0;
    enter = 0; leave = 0; exc_num = '0;
  endtask

  // model next state from current inputs, advance one clock, compare
  task automatic step();
    logic [31:0] nx;
    logic [31:0] am, em;
    nx = m_psr;
    if (flag_upd) nx[31:28] = {alu_n, alu_z, alu_c, alu_v};
    am = wmask & 32'hF800_0000;
    if (app_we) nx = (nx & ~am) | (wdata & am);
    if (sat) nx[27] = 1'b1;
    em = wmask & 32'h0600_FC00;
    if (exe_we) nx = (nx & ~em) | (wdata & em);
    nx[24] = 1'b1;
    if (enter || leave) nx[8:0] = exc_num;
    m_fault = exe_we && wmask[24] && !wdata[24];
    @(negedge clk);
    m_psr = nx;
    compare_all();
  endtask

  initial begin
    idle();
    m_psr = 32'h0100_0000;
    m_fault = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", psr, 32'h0100_0000);
    chk("R1 reset fault", {31'd0, fault}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", psr, 32'h0100_0000);

    // R2 flag load
    flag_upd = 1; alu_n = 1; alu_c = 1; step();
    chk("R2 nzcv", psr & 32'hF000_0000, 32'hA000_0000);
    idle(); step();
    chk("R2 hold", psr & 32'hF000_0000, 32'hA000_0000);

    // R3 sticky saturation
    sat = 1; step(); idle();
    flag_upd = 1; alu_z = 1; step();
    chk("R3 q survives flag update", {31'd0, psr[27]}, 32'd1);
    idle(); app_we = 1; wmask = 32'h0800_0000; wdata = 32'h0; step();
    chk("R3 q cleared by write", {31'd0, psr[27]}, 32'd0);

    // R4 masked write ignores bits outside [31:27]
    idle(); app_we = 1; wmask = 32'hFFFF_FFFF; wdata = 32'h5000_FFFF; step();
    chk("R4 app write only high bits", psr, 32'h5100_0000);

    // R5 collisions
    idle(); flag_upd = 1; alu_n = 1; alu_z = 1; alu_c = 1; alu_v = 1;
    app_we = 1; wmask = 32'hC000_0000; wdata = 32'h4000_0000; step();
    chk("R5 mask beats alu", psr & 32'hF800_0000, 32'h7000_0000);
    idle(); app_we = 1; wmask = 32'h0800_0000; wdata = 0; sat = 1; step();
    chk("R5 set beats clear", {31'd0, psr[27]}, 32'd1);

    // R6 execution write
    idle(); exe_we = 1; wmask = 32'hFFFF_FFFF; wdata = 32'hFFFF_FFFF; step();
    chk("R6 it bits set", psr & 32'h0700_FC00, 32'h0700_FC00);
    chk("R7 no fault when writing 1", {31'd0, fault}, 32'd0);

    // R7 clear attempt
    idle(); exe_we = 1; wmask = 32'h0100_0000; wdata = 0; step();
    chk("R7 fault pulse", {31'd0, fault}, 32'd1);
    chk("R7 t kept", {31'd0, psr[24]}, 32'd1);
    idle(); step();
    chk("R7 fault one cycle", {31'd0, fault}, 32'd0);

    // R8 exception entry/exit
    idle(); enter = 1; exc_num = 9'h1AB; step();
    chk("R8 enter", ipsr, 32'h0000_01AB);
    idle(); exe_we = 1; app_we = 1; wmask = '1; wdata = 0; step();
    chk("R8 writes ignored", ipsr, 32'h0000_01AB);
    idle(); leave = 1; exc_num = 9'h003; step();
    chk("R8 exit", ipsr, 32'h0000_0003);

    // random traffic, compared every clock
    for (int i = 0; i < 3000; i++) begin
      flag_upd = ($urandom_range(1) == 1);
      {alu_n, alu_z, alu_c, alu_v} = 4'($urandom);
      sat      = ($urandom_range(6) == 0);
      app_we   = ($urandom_range(3) == 0);
      exe_we   = ($urandom_range(3) == 0);
      wdata    = $urandom;
      wmask    = $urandom;
      enter    = ($urandom_range(9) == 0);
      leave    = ($urandom_range(9) == 0);
      exc_num  = 9'($urandom);
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule